// File: doc/BRIEF.md
# Dual Retriggerable Clocked One-Shot

This block is a two-channel pulse stretcher that stands in for a resistor-capacitor monostable inside a synchronous design. Each channel watches two trigger pins of opposite polarity: a rising-edge pin and a falling-edge pin. The level of each pin gates the other, so either one can serve as an inhibit. A qualifying edge drives the channel output high for a programmed number of clock cycles. A second qualifying edge during the pulse restarts the full interval. Each channel also has a complementary output.

The trigger pins and the per-channel clear pass through two-flop synchronizers, so the pins may be asynchronous to the clock. After each accepted trigger, further triggers are locked out for a short, configurable number of cycles. This models the discharge phase of the analog part. An active-low clear acts at once: it drops the output and aborts the pulse. The clear needs no recovery time, so a trigger edge that arrives together with its release still fires. The pulse length comes from a per-channel 16-bit value that is captured at each trigger.

Top module: `dual_oneshot`

## Requirements
- R1: While `rst_n` is low, every `q` bit is 0 and every `q_n` bit is 1.
- R2: A 0-to-1 change on `trig_hi[i]` while `trig_lo_n[i]` is 1 and `clr_n[i]` is 1 starts a pulse. `q[i]` rises on the third rising clock edge after the pin changes.
- R3: A 1-to-0 change on `trig_lo_n[i]` while `trig_hi[i]` is 0 starts a pulse with the same latency. Holding `trig_hi[i]` at 1 blocks falling edges on `trig_lo_n[i]`, and holding `trig_lo_n[i]` at 0 blocks rising edges on `trig_hi[i]`.
- R4: The pulse lasts exactly max(L,1) clock cycles. L is `pulse_len[i*16 +: 16]`, captured when the trigger is accepted, so a later change of L does not alter a running pulse.
- R5: A trigger accepted while `q[i]` is high restarts the timing, so `q[i]` stays high until L cycles after the latest accepted trigger.
- R6: After an accepted trigger, triggers in the next LOCK_CYC cycles are ignored. With the default of 2, pin edges 3 cycles apart are both accepted, and a second edge 2 cycles after the first is ignored.
- R7: `clr_n[i]` low forces `q[i]` to 0 and `q_n[i]` to 1 without waiting for a clock edge and aborts any running pulse. Edges while it is low are ignored.
- R8: An edge that reaches the pin in the same cycle as the release of `clr_n[i]` is accepted. An edge one cycle before the release is ignored.
- R9: `q_n` is always the bitwise complement of `q`.
- R10: Channels are independent. Clearing or triggering one channel does not affect the other, and equal lengths give equal widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| trig_hi | input | NCH | Rising-edge trigger pin per channel |
| trig_lo_n | input | NCH | Falling-edge trigger pin per channel |
| clr_n | input | NCH | Active-low asynchronous clear per channel |
| pulse_len | input | NCH*LEN_W | Pulse length in cycles, LEN_W bits per channel |
| q | output | NCH | Pulse output per channel |
| q_n | output | NCH | Complement of q |

## Verification
A pin change made after clock edge n reaches the output at edge n+3: two synchronizer stages, then the pulse register. The pulse falls max(L,1) edges after it rises, or L edges after the last accepted retrigger. The bench drives inputs and samples outputs on falling clock edges, and a monitor records the cycle of every output transition. The checks therefore compare exact latencies and widths against these counts, including edges at the lockout and clear-release boundaries. A clear acts without a clock, so its effect is checked one time unit after it is driven.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2
    } trig_src_e;

    // True when the sample moved into the wanted level this cycle
    function automatic logic lvl_edge(logic cur, logic prev, logic want);
        return (cur == want) && (prev != want);
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/oneshot_channel.sv
module oneshot_channel
    import oneshot_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int LOCK_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arst_n,
    input  logic             trig_hi,
    input  logic             trig_lo_n,
    input  logic [LEN_W-1:0] len,
    output logic             accept,
    output logic             pulse
);
    localparam int LOCK_W = $clog2(LOCK_CYC + 1);

    logic a_s, b_s, clr_ok;

    oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_a (
        .clk(clk), .arst_n(rst_n), .din(trig_hi), .dout(a_s));
    oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_b (
        .clk(clk), .arst_n(rst_n), .din(trig_lo_n), .dout(b_s));
    // Clear release passes through its own synchronizer; assertion is immediate
    oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clr (
        .clk(clk), .arst_n(arst_n), .din(1'b1), .dout(clr_ok));

    typedef struct packed {
        logic a_prev;
        logic b_prev;
    } edge_t;

    typedef struct packed {
        logic             run;
        logic [LEN_W-1:0] cnt;
        logic [LOCK_W-1:0] lock;
    } tmr_t;

    edge_t     edg_d, edg_q;
    tmr_t      tmr_d, tmr_q;
    trig_src_e src;

    always_comb begin
        edg_d.a_prev = a_s;
        edg_d.b_prev = b_s;

        src = SRC_NONE;
        if (clr_ok && (tmr_q.lock == '0)) begin
            if (lvl_edge(a_s, edg_q.a_prev, 1'b1) && b_s)
                src = SRC_RISE;
            else if (lvl_edge(b_s, edg_q.b_prev, 1'b0) && !a_s)
                src = SRC_FALL;
        end

        tmr_d = tmr_q;
        if (tmr_q.lock != '0)
            tmr_d.lock = tmr_q.lock - 1'b1;
        if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
        if (src != SRC_NONE) begin
            tmr_d.run  = 1'b1;
            tmr_d.cnt  = (len == '0) ? '0 : len - 1'b1;
            tmr_d.lock = LOCK_W'(LOCK_CYC);
        end
    end

    // Edge history follows the pins even while the channel is cleared
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edg_q <= '{a_prev: 1'b0, b_prev: 1'b1};
        else        edg_q <= edg_d;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign accept = (src != SRC_NONE);
    assign pulse  = tmr_q.run;
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
    parameter int NCH         = 2,
    parameter int LEN_W       = 16,
    parameter int LOCK_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       trig_hi,
    input  logic [NCH-1:0]       trig_lo_n,
    input  logic [NCH-1:0]       clr_n,
    input  logic [NCH*LEN_W-1:0] pulse_len,
    output logic [NCH-1:0]       q,
    output logic [NCH-1:0]       q_n
);
    logic [NCH-1:0] accept;
    logic [NCH-1:0] ch_arst_n;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_arst_n[g] = rst_n & clr_n[g];

        oneshot_channel #(
            .LEN_W(LEN_W), .LOCK_CYC(LOCK_CYC), .SYNC_STAGES(SYNC_STAGES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .arst_n   (ch_arst_n[g]),
            .trig_hi  (trig_hi[g]),
            .trig_lo_n(trig_lo_n[g]),
            .len      (pulse_len[g*LEN_W +: LEN_W]),
            .accept   (accept[g]),
            .pulse    (q[g])
        );
    end

    assign q_n = ~q;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
    parameter int NCH      = 2,
    parameter int LOCK_CYC = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] clr_n,
    input logic [NCH-1:0] q,
    input logic [NCH-1:0] accept
);
    localparam int GAP_W = $clog2(LOCK_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(LOCK_CYC);

    for (genvar g = 0; g < NCH; g++) begin : g_c
        logic [GAP_W-1:0] gap_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              gap_q <= GAP_MAX;
            else if (!clr_n[g])      gap_q <= GAP_MAX;
            else if (accept[g])      gap_q <= '0;
            else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
        end

        // R7
        clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_n[g] |-> !q[g]);

        // R2
        rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q[g]) |-> $past(accept[g]));

        // R5
        accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (accept[g] && clr_n[g]) |=> (q[g] || !clr_n[g]));

        // R6
        lockout_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            accept[g] |-> (gap_q == GAP_MAX));
    end
endmodule

bind dual_oneshot oneshot_chk #(.NCH(NCH), .LOCK_CYC(LOCK_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .q     (q),
    .accept(accept)
);

// File: tb/dual_oneshot_test.sv
module dual_oneshot_test;
    localparam int CLK_P = 10;
    localparam int LW    = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    a, b, clr;
    logic [2*LW-1:0] lens;
    logic [1:0]    q, q_n;

    int cyc = 0;
    int checks = 0;
    int fails  = 0;
    int rise_c [2];
    int fall_c [2];
    int nrise  [2];
    logic seen [2];

    dual_oneshot uut (
        .clk(clk), .rst_n(rst_n), .trig_hi(a), .trig_lo_n(b), .clr_n(clr),
        .pulse_len(lens), .q(q), .q_n(q_n));

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int c = 0; c < 2; c++) begin
            rise_c[c] = 0; fall_c[c] = 0; nrise[c] = 0; seen[c] = 1'b0;
        end
    end

    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (q[c] && !seen[c]) begin rise_c[c] = cyc; nrise[c]++; end
            if (!q[c] && seen[c]) fall_c[c] = cyc;
            seen[c] = q[c];
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_len(input int c, input int v);
        lens[c*LW +: LW] = LW'(v);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; a = 2'b00; b = 2'b11; clr = 2'b11; lens = '0;
        step(3);
        chk("R1 q in reset", int'(q), 0);
        chk("R1 q_n in reset", int'(q_n), 3);
        rst_n = 1'b1;
        step(3);
    endtask

    task automatic t_single_rise;
        int d, n0;
        set_len(0, 5); n0 = nrise[0];
        step(1); d = cyc; a[0] = 1'b1;
        step(5);
        chk("R9 q_n low in pulse", int'(q_n[0]), 0);
        step(8);
        chk("R2 rise latency", rise_c[0] - d, 3);
        chk("R4 width 5", fall_c[0] - rise_c[0], 5);
        chk("R2 one pulse", nrise[0] - n0, 1);
        chk("R9 q_n high after", int'(q_n[0]), 1);
        a[0] = 1'b0; step(4);
    endtask

    task automatic t_single_fall;
        int d;
        set_len(1, 7);
        step(1); d = cyc; b[1] = 1'b0;
        step(14);
        chk("R3 fall-edge latency", rise_c[1] - d, 3);
        chk("R3 fall-edge width", fall_c[1] - rise_c[1], 7);
        b[1] = 1'b1; step(4);
    endtask

    task automatic t_zero_len;
        set_len(0, 0);
        step(1); a[0] = 1'b1;
        step(8);
        chk("R4 zero length width", fall_c[0] - rise_c[0], 1);
        a[0] = 1'b0; step(4);
    endtask

    task automatic t_retrigger;
        int n0;
        set_len(0, 8); n0 = nrise[0];
        step(1); a[0] = 1'b1;
        step(1); a[0] = 1'b0;
        step(2); a[0] = 1'b1;           // 3 cycles after first edge
        step(20);
        chk("R5 retrigger width", fall_c[0] - rise_c[0], 11);
        chk("R6 spacing 3 single rise", nrise[0] - n0, 1);
        a[0] = 1'b0; step(4);
    endtask

    task automatic t_lockout;
        int n0;
        set_len(0, 6); n0 = nrise[0];
        step(1); b[0] = 1'b0;
        step(1); b[0] = 1'b1;
        step(1); b[0] = 1'b0;           // 2 cycles after first edge
        step(15);
        chk("R6 lockout width", fall_c[0] - rise_c[0], 6);
        chk("R6 lockout one pulse", nrise[0] - n0, 1);
        b[0] = 1'b1; step(4);
    endtask

    task automatic t_len_change;
        set_len(0, 10);
        step(1); a[0] = 1'b1;
        step(4); set_len(0, 3);
        step(14);
        chk("R4 length held", fall_c[0] - rise_c[0], 10);
        a[0] = 1'b0; step(4);
    endtask

    task automatic t_inhibit;
        int n1;
        set_len(0, 4);
        step(1); a[0] = 1'b1;
        step(10);
        n1 = nrise[0];
        b[0] = 1'b0;                    // fall with A high
        step(8);
        chk("R3 fall blocked by A high", nrise[0] - n1, 0);
        a[0] = 1'b0; step(3);
        a[0] = 1'b1;                    // rise with B low
        step(8);
        chk("R3 rise blocked by B low", nrise[0] - n1, 0);
        chk("R3 q stays low", int'(q[0]), 0);
        a[0] = 1'b0; step(3);
        b[0] = 1'b1; step(5);
        chk("R3 restore no pulse", nrise[0] - n1, 0);
    endtask

    task automatic t_clear_mid;
        int n1;
        set_len(0, 20);
        step(1); a[0] = 1'b1;
        step(6);
        chk("R7 pulse running", int'(q[0]), 1);
        n1 = nrise[0];
        clr[0] = 1'b0;
        #1;
        chk("R7 q forced low", int'(q[0]), 0);
        chk("R7 q_n forced high", int'(q_n[0]), 1);
        step(1); a[0] = 1'b0;
        step(2); a[0] = 1'b1;
        step(4);
        chk("R7 edge in clear ignored", int'(q[0]), 0);
        clr[0] = 1'b1;
        step(25);
        chk("R7 no pulse after abort", nrise[0] - n1, 0);
        a[0] = 1'b0; step(4);
    endtask

    task automatic t_recovery;
        int d, n0;
        set_len(0, 5);
        clr[0] = 1'b0; step(3);
        d = cyc; clr[0] = 1'b1; a[0] = 1'b1;
        step(12);
        chk("R8 edge at release latency", rise_c[0] - d, 3);
        chk("R8 edge at release width", fall_c[0] - rise_c[0], 5);
        a[0] = 1'b0; step(4);
        n0 = nrise[0];
        clr[0] = 1'b0; step(3);
        a[0] = 1'b1; step(1);
        clr[0] = 1'b1;
        step(12);
        chk("R8 edge before release ignored", nrise[0] - n0, 0);
        a[0] = 1'b0; step(4);
    endtask

    task automatic t_channels;
        set_len(0, 9); set_len(1, 9);
        step(1); a = 2'b11;
        step(4); clr[1] = 1'b0;
        step(12);
        chk("R10 ch0 width with ch1 cleared", fall_c[0] - rise_c[0], 9);
        chk("R10 ch1 aborted", int'(q[1]), 0);
        clr[1] = 1'b1; a = 2'b00; step(4);
        b = 2'b00;
        step(16);
        chk("R10 equal rise", rise_c[1] - rise_c[0], 0);
        chk("R10 ch0 width", fall_c[0] - rise_c[0], 9);
        chk("R10 ch1 width", fall_c[1] - rise_c[1], 9);
        b = 2'b11; step(4);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        t_reset;
        t_single_rise;
        t_single_fall;
        t_zero_len;
        t_retrigger;
        t_lockout;
        t_len_change;
        t_inhibit;
        t_clear_mid;
        t_recovery;
        t_channels;
        summary;
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary;
        $finish;
    end
endmodule